// File: doc/BRIEF.md
# YCbCr Colour Effect Processor

This block sits in a 4:2:2 YCbCr pixel stream between the capture path and the display or compression path. It rewrites every pixel through one of five effects: pass-through, monochrome, sepia tone, colour negative or luma solarization. The same block serves live preview and captured stills. Its stage costs one clock of latency and never stalls on its own, so a new pixel can enter on every clock.

Each beat carries one 8-bit chroma sample and one 8-bit luma sample. Chroma alternates between Cb and Cr along a line. Start-of-frame and end-of-line markers travel beside the pixel they belong to. The effect is chosen by a mode input, and the block takes it up only on the first beat of a frame, so a frame is never split between two effects. The sepia chroma pair and the solarize threshold are plain configuration inputs. They act on every beat as soon as they change.

Top module: `ycc_effect_top`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the active effect is pass-through until the first beat with `in_sof` = 1 is accepted.
- R2: Mode code 0, and the unused codes 5, 6 and 7, pass `in_data` through unchanged. Chroma is bits [15:8] and luma is bits [7:0].
- R3: Mode code 1 (monochrome) sets chroma to 128 and keeps luma.
- R4: Mode code 2 (sepia) keeps luma. It sets chroma to `cfg_sepia_cb` on Cb beats and to `cfg_sepia_cr` on Cr beats. The beat that carries `in_sof`, and the first beat after a beat that carries `in_eol`, are Cb. Later beats alternate Cb, Cr.
- R5: Mode code 3 (negative) outputs 255 minus the value, for both luma and chroma.
- R6: Mode code 4 (solarize) outputs 255 minus luma only when luma is strictly greater than `cfg_sol_thresh`. Otherwise luma passes unchanged. Chroma always passes unchanged.
- R7: `cfg_mode` is sampled on the accepted beat that carries `in_sof`. That beat and every later beat up to the next such beat use the sampled mode, and changes in between have no effect.
- R8: An input beat accepted on one clock edge appears on the output right after that edge. `out_sof` and `out_eol` equal the markers of the same beat.
- R9: While `out_valid` = 1 and `out_ready` = 0, the output beat is held unchanged and no beat is lost or duplicated.
- R10: `in_ready` is 1 whenever `out_ready` is 1, so with a ready sink the block accepts one beat per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 3 | Effect code: 0 pass, 1 mono, 2 sepia, 3 negative, 4 solarize |
| cfg_sepia_cb | input | 8 | Cb value used by sepia |
| cfg_sepia_cr | input | 8 | Cr value used by sepia |
| cfg_sol_thresh | input | 8 | Solarize luma threshold |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 16 | {chroma, luma} |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eol | input | 1 | Beat is the last of a line |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 16 | Processed {chroma, luma} |
| out_sof | output | 1 | Start-of-frame marker of the output beat |
| out_eol | output | 1 | End-of-line marker of the output beat |

## Verification
Two situations are hard to reach from the ports. The first is a mode change that lands mid-frame while the output is stalled. The second is the Cb/Cr phase restart after a line of odd length. The stimulus covers both. Lines of three beats force the phase to restart on Cb after an odd count. Some frames rewrite `cfg_mode` after their first beat while the sink drops `out_ready` at random. A frame with chosen lumas just below, at and just above the solarize threshold pins down the strict comparison.

// File: rtl/ycc_fx_pkg.sv
// Shared types for the colour effect processor.
// Assumes a 3-bit effect code; unknown codes fall back to pass-through.
package ycc_fx_pkg;

    typedef enum logic [2:0] {
        FX_NORMAL = 3'd0,
        FX_MONO   = 3'd1,
        FX_SEPIA  = 3'd2,
        FX_INVERT = 3'd3,
        FX_SOLAR  = 3'd4
    } fx_mode_e;

    // Map a raw configuration code to an effect; reserved codes pass through.
    function automatic fx_mode_e fx_decode(input logic [2:0] code);
        case (code)
            3'd1:    return FX_MONO;
            3'd2:    return FX_SEPIA;
            3'd3:    return FX_INVERT;
            3'd4:    return FX_SOLAR;
            default: return FX_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/ycc_mode_track.sv
// Holds the effect in force for the current frame and the Cb/Cr phase.
// The effect is sampled on the accepted start-of-frame beat. The phase
// restarts on Cb at start-of-frame and after every end-of-line beat.
// Assumes beat_fire is high for exactly the beats the pipeline accepts.
module ycc_mode_track
    import ycc_fx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_mode,
    input  logic       beat_fire,
    input  logic       beat_sof,
    input  logic       beat_eol,
    output fx_mode_e   eff_mode,
    output logic       eff_is_cr
);

    fx_mode_e active_q;
    logic     phase_q;
    fx_mode_e cfg_dec;

    assign cfg_dec   = fx_decode(cfg_mode);
    // The start-of-frame beat already uses the newly sampled effect.
    assign eff_mode  = beat_sof ? cfg_dec : active_q;
    assign eff_is_cr = beat_sof ? 1'b0 : phase_q;

    // Latch the effect at frame start and advance the chroma phase per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= FX_NORMAL;
            phase_q  <= 1'b0;
        end else if (beat_fire) begin
            if (beat_sof) begin
                active_q <= cfg_dec;
            end
            phase_q <= beat_eol ? 1'b0 : ~eff_is_cr;
        end
    end

    // R7
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_fire && beat_sof) |=> $stable(active_q));

    // R4
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && beat_eol) |=> !phase_q);

endmodule

// File: rtl/ycc_fx_datapath.sv
// Combinational transform of one {chroma, luma} beat under the given effect.
// Assumes the caller supplies the effect and the Cb/Cr phase of this beat.
module ycc_fx_datapath
    import ycc_fx_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  fx_mode_e           mode,
    input  logic               is_cr,
    input  logic [COMP_W-1:0]  y_in,
    input  logic [COMP_W-1:0]  c_in,
    input  logic [COMP_W-1:0]  sepia_cb,
    input  logic [COMP_W-1:0]  sepia_cr,
    input  logic [COMP_W-1:0]  sol_thresh,
    output logic [COMP_W-1:0]  y_out,
    output logic [COMP_W-1:0]  c_out
);

    localparam logic [COMP_W-1:0] CHROMA_MID = COMP_W'(1) << (COMP_W - 1);

    // Select the luma and chroma rewrite for the active effect.
    always_comb begin
        y_out = y_in;
        c_out = c_in;
        case (mode)
            FX_MONO:   c_out = CHROMA_MID;
            FX_SEPIA:  c_out = is_cr ? sepia_cr : sepia_cb;
            FX_INVERT: begin
                y_out = ~y_in;
                c_out = ~c_in;
            end
            FX_SOLAR:  if (y_in > sol_thresh) y_out = ~y_in;
            default:   ;
        endcase
    end

endmodule

// File: rtl/ycc_out_stage.sv
// One-entry registered output stage with valid/ready flow control.
// It accepts a new beat whenever it is empty or is draining this cycle,
// so it sustains one beat per clock against a ready sink.
module ycc_out_stage #(
    parameter int PAY_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [PAY_W-1:0]  up_payload,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [PAY_W-1:0]  dn_payload
);

    logic             full_q;
    logic [PAY_W-1:0] hold_q;

    assign up_ready   = !full_q || dn_ready;
    assign dn_valid   = full_q;
    assign dn_payload = hold_q;

    // Load on accept, empty when the sink takes the beat without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (up_valid && up_ready) begin
            full_q <= 1'b1;
            hold_q <= up_payload;
        end else if (dn_ready) begin
            full_q <= 1'b0;
        end
    end

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_payload)));

    // R8
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> dn_valid);

endmodule

// File: rtl/ycc_effect_top.sv
// Streaming colour effect processor for 4:2:2 YCbCr, one beat per clock.
// Beat layout is {chroma, luma}. The effect is fixed per frame at the
// accepted start-of-frame beat. Sepia values and the threshold act live.
module ycc_effect_top
    import ycc_fx_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_mode,
    input  logic [COMP_W-1:0]   cfg_sepia_cb,
    input  logic [COMP_W-1:0]   cfg_sepia_cr,
    input  logic [COMP_W-1:0]   cfg_sol_thresh,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2*COMP_W-1:0] in_data,
    input  logic                in_sof,
    input  logic                in_eol,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*COMP_W-1:0] out_data,
    output logic                out_sof,
    output logic                out_eol
);

    localparam int PIX_W = 2 * COMP_W;
    localparam int PAY_W = PIX_W + 2;
    localparam logic [COMP_W-1:0] CHROMA_MID = COMP_W'(1) << (COMP_W - 1);

    logic              fire;
    fx_mode_e          eff_mode;
    logic              eff_is_cr;
    logic [COMP_W-1:0] y_fx;
    logic [COMP_W-1:0] c_fx;
    logic [PAY_W-1:0]  pay_in;
    logic [PAY_W-1:0]  pay_out;

    assign fire   = in_valid && in_ready;
    assign pay_in = {in_sof, in_eol, c_fx, y_fx};

    ycc_mode_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .beat_fire (fire),
        .beat_sof  (in_sof),
        .beat_eol  (in_eol),
        .eff_mode  (eff_mode),
        .eff_is_cr (eff_is_cr)
    );

    ycc_fx_datapath #(.COMP_W(COMP_W)) u_fx (
        .mode       (eff_mode),
        .is_cr      (eff_is_cr),
        .y_in       (in_data[COMP_W-1:0]),
        .c_in       (in_data[PIX_W-1:COMP_W]),
        .sepia_cb   (cfg_sepia_cb),
        .sepia_cr   (cfg_sepia_cr),
        .sol_thresh (cfg_sol_thresh),
        .y_out      (y_fx),
        .c_out      (c_fx)
    );

    ycc_out_stage #(.PAY_W(PAY_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (in_valid),
        .up_ready   (in_ready),
        .up_payload (pay_in),
        .dn_valid   (out_valid),
        .dn_ready   (out_ready),
        .dn_payload (pay_out)
    );

    assign out_sof  = pay_out[PAY_W-1];
    assign out_eol  = pay_out[PAY_W-2];
    assign out_data = pay_out[PIX_W-1:0];

    // R5
    negative_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == FX_INVERT) |=> (out_data == ~$past(in_data)));

    // R3
    mono_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eff_mode == FX_MONO) |=>
        (out_data[PIX_W-1:COMP_W] == CHROMA_MID &&
         out_data[COMP_W-1:0] == $past(in_data[COMP_W-1:0])));

    // R10
    sink_ready_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && in_valid) |=> out_valid);

endmodule

// File: tb/tb_ycc_effect_top.sv
module tb_ycc_effect_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic [7:0]  cfg_sepia_cb = 8'd115;
    logic [7:0]  cfg_sepia_cr = 8'd145;
    logic [7:0]  cfg_sol_thresh = 8'd128;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        out_sof;
    logic        out_eol;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit bp_en = 0;
    bit monitor_on = 0;

    // behavioural reference state
    int m_mode = 0;
    int m_cr = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ycc_effect_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_sepia_cb(cfg_sepia_cb), .cfg_sepia_cr(cfg_sepia_cr),
        .cfg_sol_thresh(cfg_sol_thresh),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // sink back-pressure
    always @(negedge clk) out_ready <= bp_en ? ($urandom % 3 != 0) : 1'b1;

    // reference model: monitor just after the falling edge
    always @(negedge clk) begin
        #2;
        if (monitor_on) begin
            int eff, y, c, cr;
            string tag;
            // R10: a ready sink never blocks the input
            if (out_ready && !in_ready) check(0, "R10", in_ready, 1);
            // R8: one-cycle latency, so output valid iff a beat is owed
            if (out_valid != (exp_q.size() != 0))
                check(0, "R8", out_valid, exp_q.size() != 0);
            if (out_valid && exp_q.size() != 0) begin
                check({out_sof, out_eol} == exp_q[0][17:16], "R8", {out_sof, out_eol}, exp_q[0][17:16]);
                check(out_data == exp_q[0][15:0], tag_q[0], out_data, exp_q[0][15:0]);
                if (out_ready) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                eff = in_sof ? ((cfg_mode <= 4) ? int'(cfg_mode) : 0) : m_mode;
                cr  = in_sof ? 0 : m_cr;
                y = in_data[7:0];
                c = in_data[15:8];
                case (eff)
                    1: begin c = 128; tag = "R3"; end
                    2: begin c = cr ? cfg_sepia_cr : cfg_sepia_cb; tag = "R4"; end
                    3: begin y = 255 - y; c = 255 - c; tag = "R5"; end
                    4: begin if (y > cfg_sol_thresh) y = 255 - y; tag = "R6"; end
                    default: tag = "R2";
                endcase
                if (!in_sof) tag = {tag, " (frame mode held, R7)"};
                if (in_sof) m_mode = eff;
                m_cr = in_eol ? 0 : (cr ? 0 : 1);
                exp_q.push_back({in_sof, in_eol, c[7:0], y[7:0]});
                tag_q.push_back(tag);
            end
        end
    end

    // push one beat, waiting for acceptance (called right after a falling edge)
    task automatic push_beat(input logic [15:0] d, input bit sof, input bit eol, input bit gaps);
        bit acc;
        if (gaps && ($urandom % 4 == 0)) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data = d;
        in_sof = sof;
        in_eol = eol;
        forever begin
            #1 acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eol = 1'b0;
    endtask

    task automatic send_frame(input int mode, input int lines, input int ppl,
                              input int mid_mode, input bit gaps);
        cfg_mode = 3'(mode);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < ppl; p++) begin
                push_beat(16'($urandom), (l == 0 && p == 0), (p == ppl - 1), gaps);
                if (mid_mode >= 0 && l == 0 && p == 0) cfg_mode = 3'(mid_mode);
            end
        end
    endtask

    task automatic drain();
        bp_en = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #150000;
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1;
        // R1: before any start-of-frame the pass-through effect applies
        cfg_mode = 3'd3;
        for (int i = 0; i < 4; i++) push_beat(16'($urandom), 0, (i == 3), 0);
        // R2..R6 plus reserved codes, ready sink, back-to-back (R10)
        for (int m = 0; m < 8; m++) send_frame(m, 2, 6, -1, 0);
        // R4: odd line length forces Cb restart after every end-of-line
        send_frame(2, 3, 3, -1, 1);
        cfg_sepia_cb = 8'd40;
        cfg_sepia_cr = 8'd200;
        send_frame(2, 2, 5, -1, 0);
        cfg_sepia_cb = 8'd115;
        cfg_sepia_cr = 8'd145;
        // R7: mode rewritten after the first beat, with a stalling sink (R9)
        bp_en = 1;
        send_frame(1, 3, 4, 3, 1);
        send_frame(3, 2, 6, 4, 1);
        send_frame(4, 3, 5, 0, 1);
        send_frame(0, 2, 4, 2, 1);
        drain();
        // R6: threshold boundary lumas below, at and above
        cfg_sol_thresh = 8'd100;
        cfg_mode = 3'd4;
        push_beat(16'h2063, 1, 0, 0);
        push_beat(16'h3064, 0, 0, 0);
        push_beat(16'h4065, 0, 0, 0);
        push_beat(16'h50FF, 0, 0, 0);
        push_beat(16'h6000, 0, 1, 0);
        // R9: long random stall run over all modes
        bp_en = 1;
        for (int m = 0; m < 5; m++) send_frame(m, 4, 8, (m + 2) % 5, 1);
        drain();
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        finish_run();
    end

endmodule